// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural register state of a 32-bit processor core. It presents sixteen registers R0 to R15 and a current status word, but the physical copy that an address reaches depends on the operating mode held in the mode bits of that status word. Each exception mode has its own stack pointer, its own link register and its own saved-status word. The fast-interrupt mode also has a private set of R8 to R12. User and System mode share one bank and have no saved-status word.

Decode logic drives two read ports and one write port. A separate link path serves branch-with-link. A single-cycle exception-entry strobe saves the status word, writes the return address and switches the mode, all in one cycle. R15 is the program counter. Its output is aligned to the execution state given on an input. A write to R15 raises a branch request that carries the aligned target.

Top module: `banked_regfile`

## Requirements
- R1: While `rst` is high, every general register and the PC reset to zero and the status word resets to 0x000000D3 (supervisor mode, both interrupt masks set).
- R2: Mode codes in status bits [4:0] are: user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, monitor 10110, abort 10111, undefined 11011, system 11111. Each of the six exception modes has a private R13 and R14. User, system and any other code share the base copies.
- R3: In fast-interrupt mode, R8 to R12 reach a private copy. In every mode, R0 to R7 are shared.
- R4: `lnk_en` writes `lnk_data` into the current mode's R14. When the write port targets that same register in the same cycle, the link data wins.
- R5: A read of R0 to R14 that hits a physical register being written in the same cycle, by the write port, the link path or exception entry, returns the new value.
- R6: In one cycle, `exc_en` copies the status word into the target mode's saved-status word (when the target is an exception mode), writes `exc_ret` into the target mode's R14, and replaces status bits [4:0] with `exc_mode`. All other status bits are kept. The write port, the link path and the status writes are dropped in that cycle.
- R7: In an exception mode, `spsr_o` shows that mode's saved-status word and `spsr_we` writes it. In other modes, `spsr_o` reads 0 and `spsr_we` is ignored.
- R8: `cpsr_we` replaces the whole status word on the next edge.
- R9: `pc_o` is the stored PC with the low bits cleared according to `state_i`: 0 clears [1:0], 1 clears bit 0, 2 clears nothing, and 3 behaves like 0.
- R10: A read of R15 returns `pc_o`. A write to R15 raises `br_req` in the same cycle, with `br_target` set to the write data aligned by R9. The aligned value becomes the PC on the next edge and takes priority over `pc_load_en`.
- R11: `pc_load_en` loads `pc_load_val` into the PC on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| state_i | input | 2 | Execution state (PC alignment) |
| rd_a_addr | input | 4 | Read port A address |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 4 | Read port B address |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | 4 | Write port address |
| wr_data | input | 32 | Write port data |
| lnk_en | input | 1 | Link write to current R14 |
| lnk_data | input | 32 | Return address for link write |
| exc_en | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Target mode for exception entry |
| exc_ret | input | 32 | Return address for exception entry |
| cpsr_we | input | 1 | Status word write enable |
| cpsr_wdata | input | 32 | Status word write data |
| cpsr_o | output | 32 | Current status word |
| spsr_we | input | 1 | Saved-status write enable |
| spsr_wdata | input | 32 | Saved-status write data |
| spsr_o | output | 32 | Saved-status word of current mode |
| pc_load_en | input | 1 | Sequential PC load enable |
| pc_load_val | input | 32 | Sequential PC value |
| pc_o | output | 32 | Aligned program counter |
| br_req | output | 1 | Branch request from an R15 write |
| br_target | output | 32 | Aligned branch target |

## Verification
Several functions can land in the same cycle. The write port and the link path can both target R14 of the current mode. Exception entry can arrive while a register write, a link write or a status write is pending. The bench drives these collisions on purpose, in directed cycles and at raised rates during random traffic. It points a read port at the contested address so the forwarded winner is visible in that same cycle and the stored winner one cycle later. A behavioural model predicts the outcome from the stated priorities: the link path beats the write port, and exception entry beats everything except the sequential PC load. The model is compared against every output on every clock.

// File: rtl/brf_pkg.sv
package brf_pkg;

    localparam int XLEN     = 32;
    localparam int NARCH    = 16;
    localparam int ADDR_W   = $clog2(NARCH);
    localparam int NBANK    = 7;
    localparam int BANK_W   = $clog2(NBANK);
    localparam int NSAVED   = NBANK - 1;
    localparam int NPHYS    = 32;
    localparam int PIDX_W   = $clog2(NPHYS);
    localparam int MODE_W   = 5;
    localparam int NMAP     = 4;

    localparam int HI_FIQ_BASE = 13;
    localparam int SP_BASE     = 18;
    localparam int LR_BASE     = SP_BASE + NBANK;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_MON = 5'b10110;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    localparam logic [XLEN-1:0] STATUS_RST = 32'h0000_00D3;

    typedef enum logic [1:0] {
        ST_WORD = 2'd0,
        ST_HALF = 2'd1,
        ST_BYTE = 2'd2,
        ST_RSVD = 2'd3
    } exec_state_e;

    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [PIDX_W-1:0] pidx_t;
    typedef logic [XLEN-1:0]   word_t;

    typedef struct packed {
        logic  en;
        pidx_t idx;
        word_t data;
    } gpr_wr_t;

    // Bank 0 is the shared user/system bank; 1..6 are exception banks.
    function automatic bank_t mode_bank(logic [MODE_W-1:0] m);
        bank_t b;
        case (m)
            MODE_FIQ: b = bank_t'(1);
            MODE_IRQ: b = bank_t'(2);
            MODE_SVC: b = bank_t'(3);
            MODE_MON: b = bank_t'(4);
            MODE_ABT: b = bank_t'(5);
            MODE_UND: b = bank_t'(6);
            default:  b = bank_t'(0);
        endcase
        return b;
    endfunction

    function automatic logic has_saved(logic [MODE_W-1:0] m);
        return mode_bank(m) != bank_t'(0);
    endfunction

    function automatic pidx_t phys_index(logic [ADDR_W-1:0] a, bank_t b);
        pidx_t p;
        if (a < ADDR_W'(8))
            p = pidx_t'(a);
        else if (a < ADDR_W'(13))
            p = (b == bank_t'(1)) ? pidx_t'(a) + pidx_t'(HI_FIQ_BASE - 8) : pidx_t'(a);
        else if (a == ADDR_W'(13))
            p = pidx_t'(SP_BASE) + pidx_t'(b);
        else if (a == ADDR_W'(14))
            p = pidx_t'(LR_BASE) + pidx_t'(b);
        else
            p = pidx_t'(0);
        return p;
    endfunction

    function automatic word_t align_pc(word_t v, exec_state_e s);
        word_t r;
        case (s)
            ST_HALF: r = {v[XLEN-1:1], 1'b0};
            ST_BYTE: r = v;
            default: r = {v[XLEN-1:2], 2'b00};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/brf_addr_map.sv
module brf_addr_map
    import brf_pkg::*;
(
    input  logic [ADDR_W-1:0] arch_addr,
    input  bank_t             bank,
    output pidx_t             pidx
);
    always_comb pidx = phys_index(arch_addr, bank);
endmodule

// File: rtl/brf_gpr_store.sv
module brf_gpr_store
    import brf_pkg::*;
#(
    parameter int NENT = NPHYS,
    parameter int NRD  = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  gpr_wr_t wr_port,
    input  gpr_wr_t wr_link,
    input  pidx_t   rd_idx  [NRD],
    output word_t   rd_data [NRD]
);
    word_t mem [NENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NENT; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < NENT; i++) begin
                if (wr_link.en && wr_link.idx == PIDX_W'(i))
                    mem[i] <= wr_link.data;
                else if (wr_port.en && wr_port.idx == PIDX_W'(i))
                    mem[i] <= wr_port.data;
            end
        end
    end

    // Reads see the value that this cycle's writes will leave behind.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (wr_link.en && wr_link.idx == rd_idx[p])
                rd_data[p] = wr_link.data;
            else if (wr_port.en && wr_port.idx == rd_idx[p])
                rd_data[p] = wr_port.data;
            else
                rd_data[p] = mem[rd_idx[p]];
        end
    end
endmodule

// File: rtl/brf_status.sv
module brf_status
    import brf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_en,
    input  logic [MODE_W-1:0] exc_mode,
    input  logic              cpsr_we,
    input  word_t             cpsr_wdata,
    input  logic              spsr_we,
    input  word_t             spsr_wdata,
    output word_t             cpsr_q,
    output word_t             spsr_rd
);
    word_t saved [NSAVED];
    bank_t cur_bank;
    bank_t tgt_bank;

    always_comb begin
        cur_bank = mode_bank(cpsr_q[MODE_W-1:0]);
        tgt_bank = mode_bank(exc_mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpsr_q <= STATUS_RST;
        end else if (exc_en) begin
            cpsr_q <= {cpsr_q[XLEN-1:MODE_W], exc_mode};
        end else if (cpsr_we) begin
            cpsr_q <= cpsr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NSAVED; k++) saved[k] <= '0;
        end else begin
            for (int k = 0; k < NSAVED; k++) begin
                if (exc_en) begin
                    if (tgt_bank == BANK_W'(k + 1)) saved[k] <= cpsr_q;
                end else if (spsr_we && cur_bank == BANK_W'(k + 1)) begin
                    saved[k] <= spsr_wdata;
                end
            end
        end
    end

    always_comb begin
        spsr_rd = '0;
        for (int k = 0; k < NSAVED; k++)
            if (cur_bank == BANK_W'(k + 1)) spsr_rd = saved[k];
    end
endmodule

// File: rtl/brf_pc_unit.sv
module brf_pc_unit
    import brf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  exec_state_e state,
    input  logic        r15_we,
    input  word_t       r15_wdata,
    input  logic        load_en,
    input  word_t       load_val,
    output word_t       pc_o,
    output logic        br_req,
    output word_t       br_target
);
    word_t pc_q;

    always_comb begin
        br_req    = r15_we;
        br_target = align_pc(r15_wdata, state);
        pc_o      = align_pc(pc_q, state);
    end

    always_ff @(posedge clk) begin
        if (rst)          pc_q <= '0;
        else if (r15_we)  pc_q <= br_target;
        else if (load_en) pc_q <= load_val;
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import brf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  state_i,
    input  logic [3:0]  rd_a_addr,
    output logic [31:0] rd_a_data,
    input  logic [3:0]  rd_b_addr,
    output logic [31:0] rd_b_data,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        lnk_en,
    input  logic [31:0] lnk_data,
    input  logic        exc_en,
    input  logic [4:0]  exc_mode,
    input  logic [31:0] exc_ret,
    input  logic        cpsr_we,
    input  logic [31:0] cpsr_wdata,
    output logic [31:0] cpsr_o,
    input  logic        spsr_we,
    input  logic [31:0] spsr_wdata,
    output logic [31:0] spsr_o,
    input  logic        pc_load_en,
    input  logic [31:0] pc_load_val,
    output logic [31:0] pc_o,
    output logic        br_req,
    output logic [31:0] br_target
);
    localparam logic [ADDR_W-1:0] PC_ADDR = ADDR_W'(NARCH - 1);
    localparam logic [ADDR_W-1:0] LR_ADDR = ADDR_W'(NARCH - 2);
    localparam int P_RDA = 0, P_RDB = 1, P_WR = 2, P_LNK = 3;

    word_t             status_q;
    bank_t             cur_bank;
    bank_t             exc_bank;
    logic [ADDR_W-1:0] map_addr [NMAP];
    bank_t             map_bank [NMAP];
    pidx_t             map_idx  [NMAP];
    gpr_wr_t           wr_port;
    gpr_wr_t           wr_link;
    pidx_t             rd_idx   [2];
    word_t             rd_val   [2];
    logic              r15_we;
    word_t             pc_val;

    always_comb begin
        cur_bank = mode_bank(status_q[MODE_W-1:0]);
        exc_bank = mode_bank(exc_mode);

        map_addr[P_RDA] = rd_a_addr;  map_bank[P_RDA] = cur_bank;
        map_addr[P_RDB] = rd_b_addr;  map_bank[P_RDB] = cur_bank;
        map_addr[P_WR]  = wr_addr;    map_bank[P_WR]  = cur_bank;
        map_addr[P_LNK] = LR_ADDR;    map_bank[P_LNK] = exc_en ? exc_bank : cur_bank;
    end

    for (genvar p = 0; p < NMAP; p++) begin : g_map
        brf_addr_map u_map (
            .arch_addr (map_addr[p]),
            .bank      (map_bank[p]),
            .pidx      (map_idx[p])
        );
    end

    always_comb begin
        wr_port.en   = wr_en && !exc_en && (wr_addr != PC_ADDR);
        wr_port.idx  = map_idx[P_WR];
        wr_port.data = wr_data;
        wr_link.en   = exc_en || lnk_en;
        wr_link.idx  = map_idx[P_LNK];
        wr_link.data = exc_en ? exc_ret : lnk_data;
        rd_idx[0]    = map_idx[P_RDA];
        rd_idx[1]    = map_idx[P_RDB];
        r15_we       = wr_en && !exc_en && (wr_addr == PC_ADDR);
    end

    brf_gpr_store #(.NENT(NPHYS), .NRD(2)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_port (wr_port),
        .wr_link (wr_link),
        .rd_idx  (rd_idx),
        .rd_data (rd_val)
    );

    brf_status u_status (
        .clk        (clk),
        .rst        (rst),
        .exc_en     (exc_en),
        .exc_mode   (exc_mode),
        .cpsr_we    (cpsr_we),
        .cpsr_wdata (cpsr_wdata),
        .spsr_we    (spsr_we),
        .spsr_wdata (spsr_wdata),
        .cpsr_q     (status_q),
        .spsr_rd    (spsr_o)
    );

    brf_pc_unit u_pc (
        .clk       (clk),
        .rst       (rst),
        .state     (exec_state_e'(state_i)),
        .r15_we    (r15_we),
        .r15_wdata (wr_data),
        .load_en   (pc_load_en),
        .load_val  (pc_load_val),
        .pc_o      (pc_val),
        .br_req    (br_req),
        .br_target (br_target)
    );

    always_comb begin
        cpsr_o    = status_q;
        pc_o      = pc_val;
        rd_a_data = (rd_a_addr == PC_ADDR) ? pc_val : rd_val[0];
        rd_b_data = (rd_b_addr == PC_ADDR) ? pc_val : rd_val[1];
    end
endmodule

// File: rtl/brf_chk.sv
module brf_chk
    import brf_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [1:0]  state_i,
    input logic [3:0]  rd_a_addr,
    input logic [31:0] rd_a_data,
    input logic        wr_en,
    input logic [3:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        lnk_en,
    input logic        exc_en,
    input logic [4:0]  exc_mode,
    input logic [31:0] cpsr_o,
    input logic [31:0] spsr_o,
    input logic [31:0] pc_o,
    input logic        br_req,
    input logic [31:0] br_target
);
    p_reset_status_r1: assert property (@(posedge clk)
        rst |=> (cpsr_o == STATUS_RST && pc_o == 32'h0));

    p_saved_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !has_saved(cpsr_o[4:0]) |-> (spsr_o == 32'h0));

    p_exc_save_r6: assert property (@(posedge clk) disable iff (rst)
        (exc_en && has_saved(exc_mode)) |=> (spsr_o == $past(cpsr_o)));

    p_exc_mode_r6: assert property (@(posedge clk) disable iff (rst)
        exc_en |=> (cpsr_o[4:0] == $past(exc_mode)));

    p_pc_word_r9: assert property (@(posedge clk) disable iff (rst)
        (state_i == 2'd0 || state_i == 2'd3) |-> (pc_o[1:0] == 2'b00));

    p_pc_half_r9: assert property (@(posedge clk) disable iff (rst)
        (state_i == 2'd1) |-> (pc_o[0] == 1'b0));

    p_branch_taken_r10: assert property (@(posedge clk) disable iff (rst)
        br_req |=> ((state_i != $past(state_i)) || (pc_o == $past(br_target))));

    p_r15_read_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == 4'd15) |-> (rd_a_data == pc_o));

    p_forward_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !exc_en && !lnk_en && wr_addr == rd_a_addr && wr_addr != 4'd15)
        |-> (rd_a_data == wr_data));
endmodule

bind banked_regfile brf_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .state_i   (state_i),
    .rd_a_addr (rd_a_addr),
    .rd_a_data (rd_a_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .lnk_en    (lnk_en),
    .exc_en    (exc_en),
    .exc_mode  (exc_mode),
    .cpsr_o    (cpsr_o),
    .spsr_o    (spsr_o),
    .pc_o      (pc_o),
    .br_req    (br_req),
    .br_target (br_target)
);

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  state_i = '0;
    logic [3:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [31:0] rd_a_data, rd_b_data;
    logic        wr_en = 0, lnk_en = 0, exc_en = 0, cpsr_we = 0, spsr_we = 0, pc_load_en = 0;
    logic [31:0] wr_data = '0, lnk_data = '0, exc_ret = '0, cpsr_wdata = '0, spsr_wdata = '0, pc_load_val = '0;
    logic [4:0]  exc_mode = 5'b10000;
    logic [31:0] cpsr_o, spsr_o, pc_o, br_target;
    logic        br_req;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    banked_regfile i_banked_regfile (.*);

    // ---------------- behavioural reference ----------------
    logic [31:0] m_lo [8],    n_lo [8];
    logic [31:0] m_hi [2][5], n_hi [2][5];
    logic [31:0] m_sp [logic [4:0]], n_sp [logic [4:0]];
    logic [31:0] m_lr [logic [4:0]], n_lr [logic [4:0]];
    logic [31:0] m_sv [logic [4:0]], n_sv [logic [4:0]];
    logic [31:0] m_cpsr, n_cpsr, m_pc, n_pc;

    function automatic bit is_exc(logic [4:0] m);
        return m inside {5'b10001, 5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11011};
    endfunction

    function automatic logic [4:0] canon(logic [4:0] m);
        return is_exc(m) ? m : 5'b10000;
    endfunction

    function automatic logic [31:0] aligned(logic [31:0] v, logic [1:0] s);
        if (s == 2'd1) return {v[31:1], 1'b0};
        if (s == 2'd2) return v;
        return {v[31:2], 2'b00};
    endfunction

    function automatic logic [31:0] next_reg(logic [3:0] a, logic [4:0] m);
        if (a < 8)  return n_lo[a];
        if (a < 13) return n_hi[(canon(m) == 5'b10001) ? 1 : 0][a - 8];
        if (a == 13) return n_sp[canon(m)];
        return n_lr[canon(m)];
    endfunction

    function automatic logic [31:0] cur_reg(logic [3:0] a, logic [4:0] m);
        if (a < 8)  return m_lo[a];
        if (a < 13) return m_hi[(canon(m) == 5'b10001) ? 1 : 0][a - 8];
        if (a == 13) return m_sp[canon(m)];
        return m_lr[canon(m)];
    endfunction

    task automatic put_reg(logic [3:0] a, logic [4:0] m, logic [31:0] v);
        if (a < 8)        n_lo[a] = v;
        else if (a < 13)  n_hi[(canon(m) == 5'b10001) ? 1 : 0][a - 8] = v;
        else if (a == 13) n_sp[canon(m)] = v;
        else              n_lr[canon(m)] = v;
    endtask

    task automatic model_reset();
        logic [4:0] keys [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11011};
        for (int i = 0; i < 8; i++) m_lo[i] = '0;
        for (int b = 0; b < 2; b++) for (int i = 0; i < 5; i++) m_hi[b][i] = '0;
        foreach (keys[k]) begin
            m_sp[keys[k]] = '0; m_lr[keys[k]] = '0; m_sv[keys[k]] = '0;
        end
        m_cpsr = 32'h0000_00D3;
        m_pc   = '0;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic predict();
        logic [4:0] md = m_cpsr[4:0];
        n_lo = m_lo; n_hi = m_hi; n_sp = m_sp; n_lr = m_lr; n_sv = m_sv;
        n_cpsr = m_cpsr; n_pc = m_pc;
        if (exc_en) begin
            if (is_exc(exc_mode)) n_sv[exc_mode] = m_cpsr;
            n_lr[canon(exc_mode)] = exc_ret;
            n_cpsr = {m_cpsr[31:5], exc_mode};
        end else begin
            if (wr_en && wr_addr != 4'd15) put_reg(wr_addr, md, wr_data);
            if (lnk_en) n_lr[canon(md)] = lnk_data;
            if (cpsr_we) n_cpsr = cpsr_wdata;
            if (spsr_we && is_exc(md)) n_sv[md] = spsr_wdata;
        end
        if (!exc_en && wr_en && wr_addr == 4'd15) n_pc = aligned(wr_data, state_i);
        else if (pc_load_en) n_pc = pc_load_val;
    endtask

    function automatic string read_tag(logic [3:0] a);
        logic [4:0] md = m_cpsr[4:0];
        if (a == 4'd15) return "R10";
        if (next_reg(a, md) !== cur_reg(a, md)) return "R5";
        if (a >= 8 && a < 13) return "R3";
        return "R2";
    endfunction

    function automatic logic [31:0] read_exp(logic [3:0] a);
        if (a == 4'd15) return aligned(m_pc, state_i);
        return next_reg(a, m_cpsr[4:0]);
    endfunction

    // Inputs are set at a falling edge; outputs are compared 1 ns later.
    task automatic settle_check();
        #1;
        predict();
        chk(read_tag(rd_a_addr), rd_a_data, read_exp(rd_a_addr));
        chk(read_tag(rd_b_addr), rd_b_data, read_exp(rd_b_addr));
        chk("R8", cpsr_o, m_cpsr);
        chk("R7", spsr_o, is_exc(m_cpsr[4:0]) ? m_sv[m_cpsr[4:0]] : 32'h0);
        chk("R9", pc_o, aligned(m_pc, state_i));
        chk("R10", {31'b0, br_req}, {31'b0, (wr_en && !exc_en && wr_addr == 4'd15)});
        if (br_req) chk("R10", br_target, aligned(wr_data, state_i));
    endtask

    task automatic commit();
        @(posedge clk);
        m_lo = n_lo; m_hi = n_hi; m_sp = n_sp; m_lr = n_lr; m_sv = n_sv;
        m_cpsr = n_cpsr; m_pc = n_pc;
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; lnk_en = 0; exc_en = 0; cpsr_we = 0; spsr_we = 0; pc_load_en = 0;
    endtask

    task automatic step();
        settle_check();
        commit();
    endtask

    function automatic logic [4:0] pick_mode(int unsigned r);
        logic [4:0] list [9] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10110,
                                 5'b10111, 5'b11011, 5'b11111, 5'b00101};
        return list[r % 9];
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] old_cpsr, r3_val, sv_svc;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state visible while reset is held
        rd_a_addr = 4'd3; rd_b_addr = 4'd13;
        chk("R1", cpsr_o, 32'h0000_00D3);
        chk("R1", pc_o, 32'h0);
        chk("R1", rd_a_data, 32'h0);
        chk("R1", rd_b_data, 32'h0);
        rst = 0;

        // R4: link path and write port collide on R14 in supervisor mode
        wr_en = 1; wr_addr = 4'd14; wr_data = 32'hAAAA_0001;
        lnk_en = 1; lnk_data = 32'h0000_B0B0;
        rd_a_addr = 4'd14;
        settle_check();
        chk("R4", rd_a_data, 32'h0000_B0B0);
        commit();
        idle();
        settle_check();
        chk("R4", rd_a_data, 32'h0000_B0B0);
        commit();

        // R6: exception entry to IRQ drops a same-cycle write to R3
        wr_en = 1; wr_addr = 4'd3; wr_data = 32'h3333_3333;
        step();
        idle();
        old_cpsr = cpsr_o; r3_val = 32'h3333_3333;
        exc_en = 1; exc_mode = 5'b10010; exc_ret = 32'h0000_0F00;
        wr_en = 1; wr_addr = 4'd3; wr_data = 32'hDEAD_0003;
        cpsr_we = 1; cpsr_wdata = 32'h0000_001F;
        step();
        idle();
        rd_a_addr = 4'd14; rd_b_addr = 4'd3;
        settle_check();
        chk("R6", rd_a_data, 32'h0000_0F00);
        chk("R6", rd_b_data, r3_val);
        chk("R6", spsr_o, old_cpsr);
        chk("R6", cpsr_o, {old_cpsr[31:5], 5'b10010});
        commit();

        // R11 and R9: sequential load, then alignment under each state
        pc_load_en = 1; pc_load_val = 32'h1234_567B; state_i = 2'd2;
        step();
        idle();
        settle_check(); chk("R11", pc_o, 32'h1234_567B); commit();
        state_i = 2'd1; settle_check(); chk("R9", pc_o, 32'h1234_567A); commit();
        state_i = 2'd0; settle_check(); chk("R9", pc_o, 32'h1234_5678); commit();

        // R7: enter supervisor, store a saved word, visit user, write is ignored there
        cpsr_we = 1; cpsr_wdata = 32'h0000_0013; step(); idle();
        spsr_we = 1; spsr_wdata = 32'h5A5A_0013; step(); idle();
        sv_svc = spsr_o;
        chk("R7", sv_svc, 32'h5A5A_0013);
        cpsr_we = 1; cpsr_wdata = 32'h0000_0010; step(); idle();
        spsr_we = 1; spsr_wdata = 32'hFFFF_FFFF; step(); idle();
        settle_check(); chk("R7", spsr_o, 32'h0); commit();
        cpsr_we = 1; cpsr_wdata = 32'h0000_0013; step(); idle();
        settle_check(); chk("R7", spsr_o, 32'h5A5A_0013); commit();

        // R3: FIQ private R8 versus user R8
        wr_en = 1; wr_addr = 4'd8; wr_data = 32'h0000_0008; step(); idle();
        cpsr_we = 1; cpsr_wdata = 32'h0000_0011; step(); idle();
        rd_a_addr = 4'd8; settle_check(); chk("R3", rd_a_data, 32'h0); commit();

        // Random traffic with raised collision rates
        for (int n = 0; n < 1500; n++) begin
            wr_en      = ($urandom % 2) == 0;
            wr_addr    = (($urandom % 8) == 0) ? 4'd15 : 4'($urandom % 15);
            wr_data    = $urandom;
            lnk_en     = ($urandom % 5) == 0;
            lnk_data   = $urandom;
            exc_en     = ($urandom % 9) == 0;
            exc_mode   = pick_mode($urandom);
            exc_ret    = $urandom;
            cpsr_we    = ($urandom % 7) == 0;
            cpsr_wdata = {27'($urandom), pick_mode($urandom)};
            spsr_we    = ($urandom % 4) == 0;
            spsr_wdata = $urandom;
            pc_load_en = ($urandom % 3) == 0;
            pc_load_val = $urandom;
            state_i    = 2'($urandom % 4);
            rd_a_addr  = (($urandom % 3) == 0) ? wr_addr : 4'($urandom % 16);
            rd_b_addr  = (($urandom % 4) == 0) ? 4'd14 : 4'($urandom % 16);
            step();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule